// File: doc/BRIEF.md
# Joystick Position I2C Target

This block sits on an I2C bus as a target and serves one two-axis position sample: a signed X byte and a signed Y byte. Position samples come in on a parallel port with a one-cycle valid strobe. When a sample is the first one after a reset, or differs from the pair already held, it replaces that pair and raises an active-low interrupt. A bus master that sees the interrupt does a two-byte read with no register address. The first byte is X, the second is Y, and starting the Y byte releases the interrupt.

The 7-bit bus address is chosen by one strap input that is sampled only while reset is applied. A write to the control location 76h whose data has bit 1 set performs a soft reset when the STOP arrives. The soft reset clears the sample registers and samples the strap again. SCL and SDA are open-drain lines. The block only ever drives them low, through output-enable ports. After every acknowledged byte, if the transfer continues, it holds SCL low for a fixed number of system clocks while the next byte is prepared.

Top module: `joy_i2c_target`

## Requirements
- R1: The 8-bit address byte is matched against 80h/81h (write/read) when the latched strap is 1 and against 82h/83h when it is 0. A match is acknowledged by pulling SDA low in the ninth bit. Any other address is not acknowledged, and SDA is left released until the next START.
- R2: The strap input is latched only during the system reset or a soft reset. Changing it while running does not change the address that is matched.
- R3: A read returns the X byte first, then the Y byte, and FFh for every byte after Y.
- R4: Every transaction starts from X. A new read after a STOP, including one that follows a write, returns X as its first byte.
- R5: After reset X and Y are 00h, and SDA, SCL and the interrupt are all released (every output-enable is 0).
- R6: A valid sample that is the first after a reset, or that differs from the held pair, updates the pair and drives the interrupt low (irq_oe=1) on the next clock. A sample equal to the held pair leaves the interrupt unchanged.
- R7: The interrupt stays asserted through the address phase. It is released when the master acknowledges the X byte and the Y byte is loaded.
- R8: The pair is copied into a shadow when a read address is acknowledged. A sample that arrives during the read does not change the bytes that read returns.
- R9: A write to location 76h with data bit 1 set (for example 9Ah) performs a soft reset at STOP: X and Y return to 00h, the interrupt is released and the strap is latched again. With data bit 1 clear (for example 98h) the write has no effect.
- R10: After each acknowledge slot that is followed by another byte, SCL is pulled low for exactly STRETCH_CYC system clocks. The hold begins only while SCL is already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| irq_oe | output | 1 | 1 pulls the open-drain interrupt line low |
| strap_i | input | 1 | Address strap: 1 selects 80h/81h, 0 selects 82h/83h |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_x | input | 8 | X position, two's complement |
| smp_y | input | 8 | Y position, two's complement |

## Verification
The address logic is checked with a sweep of all 128 seven-bit addresses for each strap setting. This shows that exactly one address is acknowledged and that every other one leaves SDA released. Reads of one, two and three bytes show that the byte order is X, Y, then filler, and that the order starts again at X in every transaction. Repeated, changed and post-reset samples show when the interrupt is raised and when it is not. A sample injected in the middle of a read shows the difference between shadow capture and live register reads. Control writes with bit 1 set and clear, combined with a strap change while running, show the soft reset apart from an ignored write and from the latched address.

// File: rtl/joy_pkg.sv
// Shared types and constants for the joystick I2C target.
package joy_pkg;
    localparam int BYTE_W = 8;

    // 7-bit address used when the strap reads 1; the strap's inverse goes into bit 0.
    localparam logic [6:0] BASE_ADDR7 = 7'h40;

    // Control location and the bit position that requests a soft reset.
    localparam logic [BYTE_W-1:0] CTRL_LOC = 8'h76;
    localparam int                SRST_BIT = 1;

    // Byte sent once the X/Y pair has been read.
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_ADDR_ACK,
        BS_RD_BYTE,
        BS_RD_ACK,
        BS_WR_BYTE,
        BS_WR_ACK,
        BS_SKIP
    } bus_state_t;
endpackage

// File: rtl/joy_line_sync.sv
// Synchronizes one asynchronous bus line into the clk domain and flags its edges.
// Assumes STAGES >= 2. Released lines idle high, so the flops reset to 1.
module joy_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the synchronizer and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign line_o = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev;
    assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/joy_sample_regs.sv
// Holds the X/Y pair, the interrupt, the shadow copy and the latched strap.
// Assumes soft_rst is a single-cycle pulse. Both resets clear the same state.
module joy_sample_regs
    import joy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              strap_i,
    input  logic              smp_valid,
    input  logic [BYTE_W-1:0] smp_x,
    input  logic [BYTE_W-1:0] smp_y,
    input  logic              rd_hit,
    input  logic              y_load,
    output logic [6:0]        dev_addr,
    output logic [BYTE_W-1:0] shadow_x,
    output logic [BYTE_W-1:0] shadow_y,
    output logic              irq_oe
);
    logic [BYTE_W-1:0] x_q, y_q;
    logic              fresh_q;
    logic              strap_q;
    logic              clr;
    logic              take;

    assign clr  = !rst_n || soft_rst;
    assign take = smp_valid && (fresh_q || (smp_x != x_q) || (smp_y != y_q));

    // Accept new samples and raise or release the interrupt.
    always_ff @(posedge clk) begin
        if (clr) begin
            x_q     <= '0;
            y_q     <= '0;
            fresh_q <= 1'b1;
            irq_oe  <= 1'b0;
            strap_q <= strap_i;
        end else begin
            if (take) begin
                x_q     <= smp_x;
                y_q     <= smp_y;
                fresh_q <= 1'b0;
                irq_oe  <= 1'b1;
            end else if (y_load) begin
                irq_oe  <= 1'b0;
            end
        end
    end

    // Freeze the pair for the read that has just been addressed.
    always_ff @(posedge clk) begin
        if (clr) begin
            shadow_x <= '0;
            shadow_y <= '0;
        end else if (rd_hit) begin
            shadow_x <= x_q;
            shadow_y <= y_q;
        end
    end

    assign dev_addr = {BASE_ADDR7[6:1], ~strap_q};
endmodule

// File: rtl/joy_bus_engine.sv
// Bit-level I2C target state machine: address match, byte shifting,
// acknowledge, SCL stretching and decoding of the control write.
// Assumes synchronized inputs and an SCL low phase that is long compared with
// the synchronizer latency.
module joy_bus_engine
    import joy_pkg::*;
#(
    parameter int STRETCH_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] shadow_x,
    input  logic [BYTE_W-1:0] shadow_y,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              rd_hit,
    output logic              y_load,
    output logic              soft_rst
);
    localparam int SW = $clog2(STRETCH_CYC + 1);
    localparam int CW = $clog2(BYTE_W + 1);

    bus_state_t        state;
    logic [CW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] reg_ptr;
    logic [SW-1:0]     stretch_cnt;
    logic              rnw;
    logic              past_x;
    logic              m_ack;
    logic              first_wr;
    logic              rst_pend;

    // Protocol sequencer: one transition per synchronized bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= BS_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            tx          <= '0;
            reg_ptr     <= '0;
            stretch_cnt <= '0;
            rnw         <= 1'b0;
            past_x      <= 1'b0;
            m_ack       <= 1'b0;
            first_wr    <= 1'b0;
            rst_pend    <= 1'b0;
            sda_oe      <= 1'b0;
            rd_hit      <= 1'b0;
            y_load      <= 1'b0;
            soft_rst    <= 1'b0;
        end else begin
            rd_hit   <= 1'b0;
            y_load   <= 1'b0;
            soft_rst <= 1'b0;
            if (stretch_cnt != '0) stretch_cnt <= stretch_cnt - 1'b1;

            if (start_ev) begin
                state   <= BS_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                state    <= BS_IDLE;
                sda_oe   <= 1'b0;
                soft_rst <= rst_pend;
                rst_pend <= 1'b0;
            end else begin
                unique case (state)
                    BS_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CW'(BYTE_W)) begin
                            if (shreg[7:1] == dev_addr) begin
                                sda_oe <= 1'b1;
                                rnw    <= shreg[0];
                                rd_hit <= shreg[0];
                                state  <= BS_ADDR_ACK;
                            end else begin
                                state  <= BS_SKIP;
                            end
                        end
                    end
                    BS_ADDR_ACK: begin
                        if (scl_fall) begin
                            stretch_cnt <= SW'(STRETCH_CYC);
                            bit_cnt     <= '0;
                            if (rnw) begin
                                tx     <= shadow_x;
                                sda_oe <= ~shadow_x[BYTE_W-1];
                                past_x <= 1'b0;
                                state  <= BS_RD_BYTE;
                            end else begin
                                sda_oe   <= 1'b0;
                                first_wr <= 1'b1;
                                state    <= BS_WR_BYTE;
                            end
                        end
                    end
                    BS_RD_BYTE: begin
                        if (scl_fall) begin
                            if (bit_cnt == CW'(BYTE_W - 1)) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= BS_RD_ACK;
                            end else begin
                                tx      <= {tx[BYTE_W-2:0], 1'b1};
                                sda_oe  <= ~tx[BYTE_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    BS_RD_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                stretch_cnt <= SW'(STRETCH_CYC);
                                past_x      <= 1'b1;
                                state       <= BS_RD_BYTE;
                                if (!past_x) begin
                                    tx     <= shadow_y;
                                    sda_oe <= ~shadow_y[BYTE_W-1];
                                    y_load <= 1'b1;
                                end else begin
                                    tx     <= FILL_BYTE;
                                    sda_oe <= ~FILL_BYTE[BYTE_W-1];
                                end
                            end else begin
                                state <= BS_SKIP;
                            end
                        end
                    end
                    BS_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CW'(BYTE_W)) begin
                            sda_oe <= 1'b1;
                            state  <= BS_WR_ACK;
                            if (first_wr) begin
                                reg_ptr  <= shreg;
                                first_wr <= 1'b0;
                            end else if (reg_ptr == CTRL_LOC && shreg[SRST_BIT]) begin
                                rst_pend <= 1'b1;
                            end
                        end
                    end
                    BS_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe      <= 1'b0;
                            stretch_cnt <= SW'(STRETCH_CYC);
                            bit_cnt     <= '0;
                            state       <= BS_WR_BYTE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_oe = (stretch_cnt != '0);
endmodule

// File: rtl/joy_i2c_target.sv
// Top of the joystick I2C target: line synchronizers, START/STOP detection,
// the bus engine and the sample register file.
// Assumes clk runs at least 16 times the SCL rate. Outputs are open-drain enables.
module joy_i2c_target
    import joy_pkg::*;
#(
    parameter int STRETCH_CYC = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq_oe,
    input  logic              strap_i,
    input  logic              smp_valid,
    input  logic [BYTE_W-1:0] smp_x,
    input  logic [BYTE_W-1:0] smp_y
);
    localparam int N_LINES = 2;
    localparam int LN_SCL  = 0;
    localparam int LN_SDA  = 1;

    logic [N_LINES-1:0] ln_raw, ln_s, ln_rise, ln_fall;
    logic               start_ev, stop_ev;
    logic               rd_hit, y_load, soft_rst;
    logic [6:0]         dev_addr;
    logic [BYTE_W-1:0]  shadow_x, shadow_y;

    assign ln_raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        joy_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (ln_raw[g]),
            .line_o (ln_s[g]),
            .rise_o (ln_rise[g]),
            .fall_o (ln_fall[g])
        );
    end

    // SDA edges while SCL is high are bus conditions.
    assign start_ev = ln_s[LN_SCL] & ln_fall[LN_SDA];
    assign stop_ev  = ln_s[LN_SCL] & ln_rise[LN_SDA];

    joy_bus_engine #(.STRETCH_CYC(STRETCH_CYC)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (ln_s[LN_SDA]),
        .scl_rise (ln_rise[LN_SCL]),
        .scl_fall (ln_fall[LN_SCL]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .dev_addr (dev_addr),
        .shadow_x (shadow_x),
        .shadow_y (shadow_y),
        .sda_oe   (sda_oe),
        .scl_oe   (scl_oe),
        .rd_hit   (rd_hit),
        .y_load   (y_load),
        .soft_rst (soft_rst)
    );

    joy_sample_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .strap_i   (strap_i),
        .smp_valid (smp_valid),
        .smp_x     (smp_x),
        .smp_y     (smp_y),
        .rd_hit    (rd_hit),
        .y_load    (y_load),
        .dev_addr  (dev_addr),
        .shadow_x  (shadow_x),
        .shadow_y  (shadow_y),
        .irq_oe    (irq_oe)
    );
endmodule

// File: rtl/joy_i2c_target_chk.sv
// Port-level protocol checks for joy_i2c_target, attached with bind.
module joy_i2c_target_chk #(
    parameter int STRETCH_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic irq_oe,
    input logic smp_valid
);
    localparam int RW = $clog2(STRETCH_CYC + 2) + 1;

    logic [RW-1:0] hold_run;
    logic          rst_seen;

    // Count consecutive cycles with SCL pulled low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                      hold_run <= '0;
        else if (!scl_oe)                hold_run <= '0;
        else if (hold_run != '1)         hold_run <= hold_run + 1'b1;
    end

    // Remember that reset was applied on the previous edge.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
        if (rst_seen) begin
            // R5
            reset_quiet_chk: assert (!sda_oe && !scl_oe && !irq_oe);
        end
    end

    // R10
    stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> (hold_run == RW'(STRETCH_CYC)));

    // R10
    stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_run <= RW'(STRETCH_CYC));

    // R10
    stretch_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_i);

    // R1
    sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R6
    irq_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_oe) |-> $past(smp_valid));

    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_oe) |-> (!scl_i || sda_i));
endmodule

bind joy_i2c_target joy_i2c_target_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .irq_oe    (irq_oe),
    .smp_valid (smp_valid)
);

// File: tb/joy_i2c_target_tb_top.sv
// Self-checking bench: a bit-banged I2C master on wired-AND lines.
module joy_i2c_target_tb_top;
    localparam int STRETCH = 20;
    localparam int QTR     = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       strap = 1'b1;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_x = '0, smp_y = '0;
    logic       scl_oe, sda_oe, irq_oe;
    logic       scl_bus, sda_bus;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    joy_i2c_target #(.STRETCH_CYC(STRETCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq_oe(irq_oe),
        .strap_i(strap), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y)
    );

    int vecs = 0, errs = 0;
    int hi_run = 0, last_run = 0;
    logic [7:0] got [3];
    logic       ack;

    // Measure the length of each SCL hold by the target.
    always @(negedge clk) begin
        if (scl_oe) hi_run++;
        else begin
            if (hi_run != 0) last_run = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        @(negedge clk);
        while (scl_bus !== 1'b1) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qwait(); scl_up(); qwait(); qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; qwait(); scl_up(); qwait(); b = sda_bus; qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait(); scl_up(); qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait(); scl_up(); qwait(); m_sda = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            d = {d[6:0], b};
        end
        send_bit(!give_ack);
    endtask

    // Complete read of n bytes; the last byte is not acknowledged.
    task automatic read_n(input logic [6:0] a, input int n, output logic acked);
        bus_start();
        send_byte({a, 1'b1}, acked);
        if (acked)
            for (int i = 0; i < n; i++) recv_byte(got[i], i < n - 1);
        bus_stop();
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] r,
                             input logic [7:0] d, output logic acked);
        logic a2, a3;
        bus_start();
        send_byte({a, 1'b0}, acked);
        if (acked) begin
            send_byte(r, a2);
            send_byte(d, a3);
        end
        bus_stop();
    endtask

    task automatic put_sample(input logic [7:0] x, input logic [7:0] y);
        @(negedge clk); smp_x = x; smp_y = y; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic addr_probe(input logic [6:0] a, output logic acked);
        bus_start();
        send_byte({a, 1'b0}, acked);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [7:0] b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 reset state at the ports
        chk("R5 sda_oe", sda_oe, 0);
        chk("R5 scl_oe", scl_oe, 0);
        chk("R5 irq_oe", irq_oe, 0);
        read_n(7'h40, 2, ack);
        chk("R1 read ack strap1", ack, 1);
        chk("R5 X reset", got[0], 8'h00);
        chk("R5 Y reset", got[1], 8'h00);

        // R6 new sample raises the interrupt
        put_sample(8'h12, 8'hF0);
        chk("R6 irq on new", irq_oe, 1);

        // R3 / R7 ordered three-byte read with interrupt timing
        bus_start();
        send_byte({7'h40, 1'b1}, ack);
        chk("R7 irq held after address", irq_oe, 1);
        recv_byte(got[0], 1'b1);
        chk("R7 irq released at Y", irq_oe, 0);
        recv_byte(got[1], 1'b1);
        recv_byte(got[2], 1'b0);
        bus_stop();
        chk("R3 X byte", got[0], 8'h12);
        chk("R3 Y byte", got[1], 8'hF0);
        chk("R3 filler byte", got[2], 8'hFF);
        chk("R10 stretch length", last_run, STRETCH);

        // R6 repeated sample is not new
        put_sample(8'h12, 8'hF0);
        chk("R6 irq on same", irq_oe, 0);

        // R8 sample arriving mid-read leaves the pair intact
        put_sample(8'h33, 8'h44);
        bus_start();
        send_byte({7'h40, 1'b1}, ack);
        recv_byte(got[0], 1'b1);
        put_sample(8'h55, 8'h66);
        recv_byte(got[1], 1'b0);
        bus_stop();
        chk("R8 X paired", got[0], 8'h33);
        chk("R8 Y paired", got[1], 8'h44);
        chk("R6 irq after mid-read sample", irq_oe, 1);

        // R4 every transaction restarts at X
        read_n(7'h40, 1, ack);
        chk("R4 single-byte read X", got[0], 8'h55);
        read_n(7'h40, 2, ack);
        chk("R4 next read X", got[0], 8'h55);
        chk("R4 next read Y", got[1], 8'h66);
        write_reg(7'h40, 8'h05, 8'h00, ack);
        read_n(7'h40, 1, ack);
        chk("R4 read after write X", got[0], 8'h55);

        // R1 full address sweep with strap latched at 1
        for (int a = 0; a < 128; a++) begin
            addr_probe(7'(a), ack);
            chk("R1 sweep strap1", ack, (a == 8'h40) ? 1 : 0);
        end

        // R2 strap change while running has no effect
        strap = 1'b0;
        addr_probe(7'h40, ack);
        chk("R2 old address kept", ack, 1);
        addr_probe(7'h41, ack);
        chk("R2 new address ignored", ack, 0);

        // R9 control write without the reset bit is ignored
        write_reg(7'h40, 8'h76, 8'h98, ack);
        read_n(7'h40, 2, ack);
        chk("R9 no reset ack", ack, 1);
        chk("R9 no reset X", got[0], 8'h55);
        chk("R9 no reset Y", got[1], 8'h66);

        // R9 control write with the reset bit
        put_sample(8'h7F, 8'h80);
        chk("R6 irq before soft reset", irq_oe, 1);
        write_reg(7'h40, 8'h76, 8'h9A, ack);
        repeat (4) @(negedge clk);
        chk("R9 irq cleared", irq_oe, 0);
        for (int a = 0; a < 128; a++) begin
            addr_probe(7'(a), ack);
            chk("R1 R2 sweep strap0", ack, (a == 8'h41) ? 1 : 0);
        end
        read_n(7'h41, 2, ack);
        chk("R9 X cleared", got[0], 8'h00);
        chk("R9 Y cleared", got[1], 8'h00);

        // R6 first sample after reset counts even if it equals the cleared pair
        put_sample(8'h00, 8'h00);
        chk("R6 first sample irq", irq_oe, 1);
        read_n(7'h41, 2, ack);
        chk("R7 irq released after read", irq_oe, 0);

        // R2 system reset latches the strap again
        strap = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        addr_probe(7'h40, ack);
        chk("R2 relatched strap1", ack, 1);
        addr_probe(7'h41, ack);
        chk("R2 strap0 address gone", ack, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule